// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the device side of a two-wire SMBus/I2C link. It answers to one fixed 7-bit address and gives a host access to a small bank of byte registers. Both bus lines are oversampled on the system clock, and the block acts only on edges it detects in the synchronized samples. It drives SDA in open-drain style: it pulls the line low or lets it float.

In a write, the first byte after the address is a command byte. The command byte sets the sticky command pointer and a working cursor. Each further byte is stored at the cursor, and the cursor then advances. Every read phase, and every transaction, starts its cursor from the sticky pointer. As a result, a read with no command byte returns the register that was selected last.

One command value stands for a block register. Reading it gives a count byte first, then that many bytes taken from the bank starting at register 0.

Top module: `smb_target`

## Requirements
- R1: After a start, the block samples 8 bits on rising SCL, most significant bit first. The first 7 bits are the address and the 8th is the direction bit (1 = read). When the address equals `DEV_ADDR`, the block pulls SDA low for the 9th clock.
- R2: When the address does not match, the block gives no ACK. It does not drive SDA for any later bits until the next start or stop, and the bytes it ignores leave the command pointer and the registers unchanged.
- R3: In a write transaction, the first byte after the address becomes the command byte. Each later byte is stored at the cursor. The block ACKs every written byte, and a write may carry a command byte and no data.
- R4: After each data byte the cursor advances by one and wraps from `NUM_REGS-1` to 0. A word is therefore written and read low byte first, at the command address, then high byte at the next address.
- R5: The command pointer survives stops. A read with no command byte returns the register that the most recent command selected.
- R6: A repeated start is accepted at any point. The address and direction are decoded again after it, and a non-matching address in the second phase gets no ACK.
- R7: When the command pointer equals `BLK_CMD` (default 0x20), a read returns `BLK_LEN` (default 4) as its first byte. It then returns registers 0, 1, 2 and so on.
- R8: When the host NACKs a read byte (SDA high on the 9th clock), the block releases SDA. It stays released until the next start, including through the stop.
- R9: When the cursor is at `NUM_REGS` or above and is not in the block sequence, reads return 0xFF and writes are dropped.
- R10: SDA is released during and after reset. SCL pulses that arrive with no start after reset draw no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
The hardest case to reach is a read that begins from the sticky pointer after the pointer has already been moved by other traffic. This includes traffic that had to be ignored, such as a foreign address, or a repeated start whose second phase names a foreign address.

The stimulus builds such histories on purpose. It sets a command, then sends ignored writes or mixed-address repeated starts, and finally issues a bare read. The value returned by that read tells whether the pointer was kept.

Block reads that are cut short by a NACK are also run. During the stop that follows, the bench checks that SDA stays released.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WRX,
    ST_WACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_busev.sv
module smb_busev (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_smp
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      sda_smp   <= 1'b1;
    end else begin
      scl_d     <= scl_s;
      sda_d     <= sda_s;
      start_det <= scl_d & scl_s & sda_d & ~sda_s;
      stop_det  <= scl_d & scl_s & ~sda_d & sda_s;
      scl_rise  <= ~scl_d & scl_s;
      scl_fall  <= scl_d & ~scl_s;
      sda_smp   <= sda_s;
    end
  end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smb_target.sv
module smb_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         NUM_REGS    = 8,
  parameter logic [7:0] BLK_CMD     = 8'h20,
  parameter int         BLK_LEN     = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);
  import smb_pkg::*;

  localparam int         AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] LAST_REG = 8'(NUM_REGS - 1);
  localparam logic [7:0] LEN_BYTE = 8'(BLK_LEN);

  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall, sda_smp;

  smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
  smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

  smb_busev u_busev (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_smp(sda_smp));

  smb_state_e      state;
  logic [3:0]      bit_cnt;
  logic [7:0]      shreg;
  logic [7:0]      txb;
  logic [7:0]      cmd;
  logic [7:0]      cursor;
  logic            rw;
  logic            first_wr;
  logic            cnt_pend;
  logic            host_ack;
  logic            we_q;
  logic [AW-1:0]   waddr_q;
  logic [7:0]      wdata_q;
  logic [7:0]      rd_data;
  logic            in_range;
  logic [7:0]      tx_next;
  logic [7:0]      cur_step;
  logic [7:0]      load_cur;

  smb_regbank #(.DEPTH(NUM_REGS), .AW(AW), .DW(8)) u_bank (
    .clk(clk), .we(we_q), .waddr(waddr_q), .wdata(wdata_q),
    .raddr(cursor[AW-1:0]), .rdata(rd_data));

  always_comb begin
    in_range = (cursor <= LAST_REG);
    if (cursor < LAST_REG)       cur_step = cursor + 8'd1;
    else if (cursor == LAST_REG) cur_step = 8'd0;
    else                         cur_step = cursor;
    load_cur = cnt_pend ? 8'd0 : cur_step;
    if (cnt_pend)      tx_next = LEN_BYTE;
    else if (in_range) tx_next = rd_data;
    else               tx_next = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      txb      <= '0;
      cmd      <= '0;
      cursor   <= '0;
      rw       <= 1'b0;
      first_wr <= 1'b0;
      cnt_pend <= 1'b0;
      host_ack <= 1'b0;
      sda_pull <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        cursor   <= cmd;
        cnt_pend <= (cmd == BLK_CMD);
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WRX: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_smp};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_pull <= 1'b1;
                  rw       <= shreg[0];
                  first_wr <= 1'b1;
                  state    <= ST_AACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                sda_pull <= 1'b1;
                state    <= ST_WACK;
                if (first_wr) begin
                  cmd      <= shreg;
                  cursor   <= shreg;
                  cnt_pend <= (shreg == BLK_CMD);
                  first_wr <= 1'b0;
                end else begin
                  if (in_range) begin
                    we_q    <= 1'b1;
                    waddr_q <= cursor[AW-1:0];
                    wdata_q <= shreg;
                  end
                  cursor <= cur_step;
                end
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw) begin
                txb      <= tx_next;
                sda_pull <= ~tx_next[7];
                cursor   <= load_cur;
                cnt_pend <= 1'b0;
                state    <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_WRX;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_WRX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_pull <= 1'b0;
                state    <= ST_RACK;
              end else begin
                txb      <= {txb[6:0], 1'b0};
                sda_pull <= ~txb[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_smp;
            end else if (scl_fall) begin
              if (host_ack) begin
                bit_cnt  <= '0;
                txb      <= tx_next;
                sda_pull <= ~tx_next[7];
                cursor   <= load_cur;
                cnt_pend <= 1'b0;
                state    <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_IGNORE;
              end
            end
          end
          default: begin
            sda_pull <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
  input logic              clk,
  input logic              rst,
  input logic              sda_pull,
  input logic              start_det,
  input logic              stop_det,
  input logic              scl_fall,
  input smb_pkg::smb_state_e state,
  input logic [7:0]        cmd
);
  import smb_pkg::*;

  AST_RESET_RELEASE: assert property (@(posedge clk) rst |=> !sda_pull); // R10

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det)); // R1

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_pull); // R2

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull); // R8

  AST_CMD_STICKY: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> $stable(cmd)); // R5

  AST_START_REDECODE: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR)); // R6
endmodule

bind smb_target smb_target_chk u_chk (
  .clk(clk), .rst(rst), .sda_pull(sda_pull), .start_det(start_det),
  .stop_det(stop_det), .scl_fall(scl_fall), .state(state), .cmd(cmd));

// File: tb/smb_target_test.sv
module smb_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 16;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int NREG = 8;
  localparam int BLK  = 8'h20;
  localparam int BLEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_pull;
  logic sda_line;

  assign sda_line = sda_h & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_target uut (
    .clk(clk), .rst(rst), .scl_in(scl_h), .sda_in(sda_line), .sda_pull(sda_pull));

  int    n_chk = 0;
  int    n_err = 0;
  logic  chk_on = 1'b0;
  logic  exp_pull = 1'b0;
  string cur_tag = "R10";

  int m_regs [NREG];
  int m_cmd = 0;
  logic [7:0] wq [$];

  // Reference comparison on every clock while the check window is open
  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (sda_pull !== exp_pull) begin
        n_err++;
        $display("FAIL %s sda_pull actual=%b expected=%b at %0t", cur_tag, sda_pull, exp_pull, $time);
      end
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic bus_bit(input logic hb, input logic ep, output logic lv);
    waitc(2);
    sda_h = hb;
    waitc(HALF - 2);
    scl_h = 1'b1;
    waitc(6);
    exp_pull = ep;
    chk_on = 1'b1;
    waitc(HALF - 10);
    lv = sda_line;
    chk_on = 1'b0;
    waitc(4);
    scl_h = 1'b0;
  endtask

  task automatic bus_start();
    if (scl_h == 1'b0) begin
      waitc(2);
      sda_h = 1'b1;
      waitc(HALF);
      scl_h = 1'b1;
      waitc(HALF);
    end
    sda_h = 1'b0;
    waitc(HALF);
    scl_h = 1'b0;
  endtask

  task automatic bus_stop(input string tag);
    waitc(2);
    sda_h = 1'b0;
    waitc(HALF);
    scl_h = 1'b1;
    cur_tag = tag;
    waitc(6);
    exp_pull = 1'b0;
    chk_on = 1'b1;
    waitc(HALF - 6);
    chk_on = 1'b0;
    sda_h = 1'b1;
    waitc(HALF);
  endtask

  task automatic write_byte(input logic [7:0] b, input logic ack, input string tag);
    logic lv;
    cur_tag = tag;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, lv);
    bus_bit(1'b1, ack, lv);
    check8(tag, "ack line", {7'd0, lv}, {7'd0, ~ack});
  endtask

  task automatic read_byte(input logic [7:0] exp, input logic last, input string tag);
    logic lv;
    logic [7:0] got;
    cur_tag = tag;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, ~exp[i], lv);
      got[i] = lv;
    end
    bus_bit(last, 1'b0, lv);
    check8(tag, "read byte", got, exp);
  endtask

  function automatic int step(input int c);
    if (c < NREG - 1) return c + 1;
    if (c == NREG - 1) return 0;
    return c;
  endfunction

  // General transaction: optional write phase (bytes in wq), optional read phase
  task automatic xfer(input logic has_w, input logic [6:0] aw, input logic [6:0] ar,
                      input int nr, input string tag);
    int cur;
    logic m;
    logic pend;
    logic [7:0] e;
    bus_start();
    if (has_w) begin
      m = (aw == DEV);
      write_byte({aw, 1'b0}, m, tag);
      cur = m_cmd;
      for (int k = 0; k < wq.size(); k++) begin
        write_byte(wq[k], m, tag);
        if (m) begin
          if (k == 0) begin
            m_cmd = wq[k];
            cur = wq[k];
          end else begin
            if (cur < NREG) m_regs[cur] = wq[k];
            cur = step(cur);
          end
        end
      end
    end
    if (nr > 0) begin
      bus_start();
      m = (ar == DEV);
      write_byte({ar, 1'b1}, m, tag);
      if (m) begin
        cur = m_cmd;
        pend = (m_cmd == BLK);
        for (int k = 0; k < nr; k++) begin
          if (pend) begin
            e = 8'(BLEN);
            pend = 1'b0;
            cur = 0;
          end else begin
            e = (cur < NREG) ? 8'(m_regs[cur]) : 8'hFF;
            cur = step(cur);
          end
          read_byte(e, k == nr - 1, tag);
        end
      end
    end
    bus_stop(tag);
  endtask

  initial begin
    logic lv;
    for (int i = 0; i < NREG; i++) m_regs[i] = 0;
    // R10: reset state
    waitc(3);
    cur_tag = "R10";
    exp_pull = 1'b0;
    chk_on = 1'b1;
    waitc(4);
    chk_on = 1'b0;
    rst = 1'b0;
    waitc(4);
    check8("R10", "pull after reset", {7'd0, sda_pull}, 8'd0);
    // R10: clocks with no start draw no response
    scl_h = 1'b0;
    for (int i = 0; i < 9; i++) bus_bit(i[0], 1'b0, lv);
    bus_stop("R10");

    // R3 / R4: word write at command 2
    wq = {8'h02, 8'h11, 8'h22};
    xfer(1'b1, DEV, DEV, 0, "R3");
    // R4 / R6: word read through repeated start
    wq = {8'h02};
    xfer(1'b1, DEV, DEV, 2, "R4_R6");
    // R5: bare read returns register of last command
    wq = {};
    xfer(1'b0, DEV, DEV, 1, "R5");
    // R4: word write wrapping from register 7 to 0
    wq = {8'h07, 8'hA5, 8'h5A};
    xfer(1'b1, DEV, DEV, 0, "R4");
    wq = {8'h07};
    xfer(1'b1, DEV, DEV, 2, "R4");
    // R2: foreign address write is ignored, pointer kept
    wq = {8'h00, 8'hEE, 8'hEE};
    xfer(1'b1, 7'h3B, DEV, 0, "R2");
    wq = {};
    xfer(1'b0, DEV, DEV, 1, "R2");
    // R3: multi-byte write of registers 0..3
    wq = {8'h00, 8'hD0, 8'hD1, 8'hD2, 8'hD3};
    xfer(1'b1, DEV, DEV, 0, "R3");
    // R7: command-only write selects the block register, then bare read
    wq = {8'(BLK)};
    xfer(1'b1, DEV, DEV, 0, "R7");
    wq = {};
    xfer(1'b0, DEV, DEV, BLEN + 1, "R7");
    // R8: block read cut short by NACK; SDA released through the stop
    wq = {8'(BLK)};
    xfer(1'b1, DEV, DEV, 2, "R8");
    // R9: out-of-range writes dropped, reads give 0xFF
    wq = {8'h10, 8'h99, 8'h98};
    xfer(1'b1, DEV, DEV, 0, "R9");
    wq = {8'h10};
    xfer(1'b1, DEV, DEV, 2, "R9");
    wq = {8'h00};
    xfer(1'b1, DEV, DEV, 2, "R9");
    // R6: repeated start to a foreign address gets no ACK
    wq = {8'h03};
    xfer(1'b1, DEV, 7'h21, 1, "R6");
    wq = {};
    xfer(1'b0, DEV, DEV, 1, "R6");
    // R1: read addressed directly after reset-style idle
    wq = {8'h01};
    xfer(1'b1, DEV, DEV, 1, "R1");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule